// File: doc/BRIEF.md
# Serial Flash Geometry Identifier

This block works out which paged serial flash hangs off its SPI pins and reports the device's geometry. It reports the number of pages, the bytes per page, the shift that places a page number inside a device address, whether pages are a power of two in size, and the total capacity. It starts once by itself when reset is released, and again on every `start` pulse. It drives a mode-0 SPI bus directly, one byte at a time, with a configurable SCLK half period.

The block first issues the manufacturer/device ID command. If the manufacturer byte is the expected one, the 24-bit identifier is looked up. Parts that can run with either page size are then asked for their status byte, whose lowest bit selects the power-of-two page size or the extended page size (power of two plus 1/32). If the manufacturer byte is anything else, the block falls back to the status byte alone: an empty bus, a missing part or a code it does not know ends in an error code instead of a geometry.

Top module: `flash_id_engine`

## Requirements
- R1: When reset is released the block starts one identification run with no `start` pulse. The first SPI transaction sends opcode 0x9F followed by three read bytes: manufacturer, device high, device low.
- R2: Identifier 0x1F2700 selects 8192 pages of 528 bytes, shift 10, `pow2_pages`=0. This takes a single SPI transaction, with no status read.
- R3: Identifiers 0x1F2200, 0x1F2300, 0x1F2400, 0x1F2500, 0x1F2600, 0x1F2701 and 0x1F2800 trigger a second transaction that sends opcode 0xD7 and reads one status byte. Their page counts are 512, 1024, 2048, 4096, 4096, 8192 and 8192. Status bit 0 = 1 selects the power-of-two size: 256/8, 256/8, 256/8, 256/8, 512/9, 512/9 and 1024/10 (bytes/shift), with `pow2_pages`=1. Bit 0 = 0 selects 264/9, 264/9, 264/9, 264/9, 528/10, 528/10 and 1056/11, with `pow2_pages`=0. The other status bits have no effect.
- R4: When the manufacturer byte is not 0x1F, a 0xD7 status transaction follows, and status bits [5:2] (status & 0x3C) select the geometry. 0x0C gives 512×264 shift 9, 0x14 gives 1024×264 shift 9, 0x1C gives 2048×264 shift 9, 0x24 gives 4096×264 shift 9, 0x2C gives 4096×528 shift 10, 0x34 gives 8192×528 shift 10, and 0x38 or 0x3C gives 8192×1056 shift 11. All of these report `pow2_pages`=0, and the bits outside the mask are ignored.
- R5: In the fallback path a status byte of 0x00 or 0xFF ends the run with `id_error`=1, `id_valid`=0 and `err_code`=1 (no device).
- R6: A 0x1F identifier that is not listed in R2/R3 ends after the ID transaction. An unlisted fallback code also ends the run. Both report `id_error`=1 and `err_code`=2 (unsupported).
- R7: `capacity` equals `page_count` × `page_size` on every successful run, and is 0 after an error.
- R8: `done` is a one-cycle pulse that ends each run, with exactly one of `id_valid` and `id_error` set. The flags are cleared when a run starts. The geometry outputs change only with `done`. A `start` that arrives while `busy` is ignored.
- R9: While idle, `spi_cs_n` is high and `spi_sclk` is low. Every byte takes eight SCLK rising edges, MSB first. Data is sampled on the rising edge and shifted on the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a new identification run when idle |
| spi_miso | input | 1 | Serial data from the flash |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| id_valid | output | 1 | Geometry outputs hold an identified device |
| id_error | output | 1 | The last run failed |
| err_code | output | 2 | 0 none, 1 no device, 2 unsupported |
| page_count | output | 16 | Number of pages |
| page_size | output | 11 | Bytes per page |
| addr_shift | output | 4 | Bit position of the page number in a device address |
| pow2_pages | output | 1 | Page size is a power of two |
| capacity | output | 27 | Total bytes |

## Verification
The assertions assume that `spi_miso` is settled on each rising SCLK edge. They also assume that `start` is a synchronous level, which may arrive at any time, including in the middle of a run. The bench meets the first assumption with a flash model that changes its output bit only on falling SCLK edges, at least one half period ahead of sampling. It meets the second by raising and lowering `start` on falling clock edges. It also presents status bytes whose bits outside the field of interest are set, so that the result can only come from the intended bits. The flash model records each transaction's opcode and SCLK edge count.

// File: rtl/flash_id_pkg.sv
`timescale 1ns/1ps
package flash_id_pkg;

  localparam int PCOUNT_W = 16;
  localparam int PSIZE_W  = 11;
  localparam int SHIFT_W  = 4;
  localparam int CAP_W    = PCOUNT_W + PSIZE_W;

  localparam logic [7:0] OPC_READ_ID = 8'h9F;
  localparam logic [7:0] OPC_STATUS  = 8'hD7;
  localparam logic [7:0] MFR_EXPECT  = 8'h1F;
  localparam logic [7:0] DENS_MASK   = 8'h3C;

  typedef struct packed {
    logic [PCOUNT_W-1:0] pages;
    logic [PSIZE_W-1:0]  psize;
    logic [SHIFT_W-1:0]  shift;
    logic                pow2;
  } geom_t;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_NODEV = 2'd1,
    ERR_UNSUP = 2'd2
  } err_t;

  // Geometry from log2(pages) and log2 of the power-of-two page size.
  // The extended size adds 1/32 and moves the page field up by one bit.
  function automatic geom_t make_geom(input int pages_log2, input int base_log2,
                                      input logic pow2);
    geom_t g;
    g.pages = PCOUNT_W'(1) << pages_log2;
    g.pow2  = pow2;
    if (pow2) begin
      g.psize = PSIZE_W'(1) << base_log2;
      g.shift = SHIFT_W'(base_log2);
    end else begin
      g.psize = (PSIZE_W'(1) << base_log2) + (PSIZE_W'(1) << (base_log2 - 5));
      g.shift = SHIFT_W'(base_log2 + 1);
    end
    return g;
  endfunction

endpackage

// File: rtl/flash_spi_byte.sv
`timescale 1ns/1ps
module flash_spi_byte #(
  parameter int DIV_HALF = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte
);

  localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);

  logic [CNT_W-1:0] cnt;
  logic [2:0]       bit_idx;
  logic [7:0]       sh_tx;
  logic [7:0]       sh_rx;
  logic             active;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      bit_idx <= '0;
      sh_tx   <= '0;
      sh_rx   <= '0;
      active  <= 1'b0;
      sclk    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (go) begin
          active  <= 1'b1;
          sh_tx   <= tx_byte;
          cnt     <= '0;
          bit_idx <= '0;
          sclk    <= 1'b0;
        end
      end else if (cnt == CNT_LAST) begin
        cnt <= '0;
        if (!sclk) begin
          sclk  <= 1'b1;
          sh_rx <= {sh_rx[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bit_idx == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bit_idx <= bit_idx + 3'd1;
            sh_tx   <= {sh_tx[6:0], 1'b0};
          end
        end
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign mosi    = sh_tx[7];
  assign busy    = active;
  assign rx_byte = sh_rx;

  AST_SCLK_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
    !active |-> !sclk) else $error("sclk high while idle"); // R9
  AST_DONE_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    done |-> !active) else $error("done while shifting"); // R9
  AST_GO_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    active |-> !go) else $error("go while shifting"); // R9

endmodule

// File: rtl/flash_id_lookup.sv
`timescale 1ns/1ps
module flash_id_lookup
  import flash_id_pkg::*;
(
  input  logic [23:0] id_word,
  input  logic        pow2_sel,
  input  logic [7:0]  status_byte,
  output logic        jedec_hit,
  output logic        jedec_pow2_cap,
  output geom_t       jedec_geom,
  output logic        dens_hit,
  output geom_t       dens_geom
);

  int   j_pages_log2;
  int   j_base_log2;
  int   d_pages_log2;
  int   d_base_log2;
  logic [7:0] dens_code;

  // Identifier table: every device byte carries a pair of page-size variants.
  always_comb begin
    jedec_hit      = 1'b0;
    jedec_pow2_cap = 1'b1;
    j_pages_log2   = 9;
    j_base_log2    = 8;
    if (id_word[23:16] == MFR_EXPECT) begin
      case (id_word[15:8])
        8'h22: begin j_pages_log2 = 9;  j_base_log2 = 8;  jedec_hit = (id_word[7:0] == 8'h00); end
        8'h23: begin j_pages_log2 = 10; j_base_log2 = 8;  jedec_hit = (id_word[7:0] == 8'h00); end
        8'h24: begin j_pages_log2 = 11; j_base_log2 = 8;  jedec_hit = (id_word[7:0] == 8'h00); end
        8'h25: begin j_pages_log2 = 12; j_base_log2 = 8;  jedec_hit = (id_word[7:0] == 8'h00); end
        8'h26: begin j_pages_log2 = 12; j_base_log2 = 9;  jedec_hit = (id_word[7:0] == 8'h00); end
        8'h27: begin
          j_pages_log2   = 13;
          j_base_log2    = 9;
          jedec_hit      = (id_word[7:0] == 8'h00) || (id_word[7:0] == 8'h01);
          jedec_pow2_cap = (id_word[7:0] == 8'h01);
        end
        8'h28: begin j_pages_log2 = 13; j_base_log2 = 10; jedec_hit = (id_word[7:0] == 8'h00); end
        default: jedec_hit = 1'b0;
      endcase
    end
    jedec_geom = make_geom(j_pages_log2, j_base_log2, jedec_pow2_cap & pow2_sel);
  end

  // Fallback density code in status bits [5:2]; always extended page size.
  always_comb begin
    dens_code    = status_byte & DENS_MASK;
    dens_hit     = 1'b1;
    d_pages_log2 = 9;
    d_base_log2  = 8;
    case (dens_code)
      8'h0C: begin d_pages_log2 = 9;  d_base_log2 = 8;  end
      8'h14: begin d_pages_log2 = 10; d_base_log2 = 8;  end
      8'h1C: begin d_pages_log2 = 11; d_base_log2 = 8;  end
      8'h24: begin d_pages_log2 = 12; d_base_log2 = 8;  end
      8'h2C: begin d_pages_log2 = 12; d_base_log2 = 9;  end
      8'h34: begin d_pages_log2 = 13; d_base_log2 = 9;  end
      8'h38, 8'h3C: begin d_pages_log2 = 13; d_base_log2 = 10; end
      default: dens_hit = 1'b0;
    endcase
    dens_geom = make_geom(d_pages_log2, d_base_log2, 1'b0);
  end

endmodule

// File: rtl/flash_id_engine.sv
`timescale 1ns/1ps
module flash_id_engine
  import flash_id_pkg::*;
#(
  parameter int SCLK_HALF_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                spi_miso,
  output logic                spi_sclk,
  output logic                spi_cs_n,
  output logic                spi_mosi,
  output logic                busy,
  output logic                done,
  output logic                id_valid,
  output logic                id_error,
  output logic [1:0]          err_code,
  output logic [PCOUNT_W-1:0] page_count,
  output logic [PSIZE_W-1:0]  page_size,
  output logic [SHIFT_W-1:0]  addr_shift,
  output logic                pow2_pages,
  output logic [CAP_W-1:0]    capacity
);

  localparam int ID_BYTES = 3;
  localparam int RD_W     = $clog2(ID_BYTES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_XFER, ST_EVAL} state_t;
  typedef enum logic [1:0] {PH_ID, PH_QUAL, PH_LEGACY} phase_t;

  state_t          state;
  phase_t          phase;
  logic            boot_pend;
  logic [7:0]      cur_op;
  logic [RD_W-1:0] rd_left;
  logic            in_op;
  logic [23:0]     id_word;
  logic [7:0]      stat_q;

  logic            sh_go;
  logic [7:0]      sh_tx;
  logic            sh_busy;
  logic            sh_done;
  logic [7:0]      sh_rx;

  logic            jedec_hit;
  logic            jedec_pow2_cap;
  geom_t           jedec_geom;
  logic            dens_hit;
  geom_t           dens_geom;

  logic            ev_finish;
  logic            ev_launch;
  phase_t          ev_phase;
  err_t            ev_err;
  geom_t           ev_geom;

  flash_spi_byte #(.DIV_HALF(SCLK_HALF_CYCLES)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .go      (sh_go),
    .tx_byte (sh_tx),
    .miso    (spi_miso),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .busy    (sh_busy),
    .done    (sh_done),
    .rx_byte (sh_rx)
  );

  flash_id_lookup u_lookup (
    .id_word        (id_word),
    .pow2_sel       (stat_q[0]),
    .status_byte    (stat_q),
    .jedec_hit      (jedec_hit),
    .jedec_pow2_cap (jedec_pow2_cap),
    .jedec_geom     (jedec_geom),
    .dens_hit       (dens_hit),
    .dens_geom      (dens_geom)
  );

  // Decision taken in ST_EVAL after each transaction.
  always_comb begin
    ev_finish = 1'b0;
    ev_launch = 1'b0;
    ev_phase  = phase;
    ev_err    = ERR_NONE;
    ev_geom   = '0;
    case (phase)
      PH_ID: begin
        if (id_word[23:16] == MFR_EXPECT) begin
          if (!jedec_hit) begin
            ev_finish = 1'b1;
            ev_err    = ERR_UNSUP;
          end else if (jedec_pow2_cap) begin
            ev_launch = 1'b1;
            ev_phase  = PH_QUAL;
          end else begin
            ev_finish = 1'b1;
            ev_geom   = jedec_geom;
          end
        end else begin
          ev_launch = 1'b1;
          ev_phase  = PH_LEGACY;
        end
      end
      PH_QUAL: begin
        ev_finish = 1'b1;
        ev_geom   = jedec_geom;
      end
      PH_LEGACY: begin
        ev_finish = 1'b1;
        if (stat_q == 8'h00 || stat_q == 8'hFF) begin
          ev_err = ERR_NODEV;
        end else if (dens_hit) begin
          ev_geom = dens_geom;
        end else begin
          ev_err = ERR_UNSUP;
        end
      end
      default: begin
        ev_finish = 1'b1;
        ev_err    = ERR_UNSUP;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      phase      <= PH_ID;
      boot_pend  <= 1'b1;
      cur_op     <= OPC_READ_ID;
      rd_left    <= '0;
      in_op      <= 1'b0;
      id_word    <= '0;
      stat_q     <= '0;
      sh_go      <= 1'b0;
      sh_tx      <= '0;
      spi_cs_n   <= 1'b1;
      done       <= 1'b0;
      id_valid   <= 1'b0;
      id_error   <= 1'b0;
      err_code   <= ERR_NONE;
      page_count <= '0;
      page_size  <= '0;
      addr_shift <= '0;
      pow2_pages <= 1'b0;
      capacity   <= '0;
    end else begin
      done  <= 1'b0;
      sh_go <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start || boot_pend) begin
            boot_pend <= 1'b0;
            id_valid  <= 1'b0;
            id_error  <= 1'b0;
            err_code  <= ERR_NONE;
            phase     <= PH_ID;
            cur_op    <= OPC_READ_ID;
            rd_left   <= RD_W'(ID_BYTES);
            state     <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          spi_cs_n <= 1'b0;
          sh_go    <= 1'b1;
          sh_tx    <= cur_op;
          in_op    <= 1'b1;
          state    <= ST_XFER;
        end
        ST_XFER: begin
          if (sh_done) begin
            in_op <= 1'b0;
            if (!in_op) begin
              if (phase == PH_ID) id_word <= {id_word[15:0], sh_rx};
              else                stat_q  <= sh_rx;
            end
            if (rd_left == '0) begin
              spi_cs_n <= 1'b1;
              state    <= ST_EVAL;
            end else begin
              sh_go   <= 1'b1;
              sh_tx   <= 8'h00;
              rd_left <= rd_left - RD_W'(1);
            end
          end
        end
        ST_EVAL: begin
          phase <= ev_phase;
          if (ev_launch) begin
            cur_op  <= OPC_STATUS;
            rd_left <= RD_W'(1);
            state   <= ST_SETUP;
          end else begin
            state      <= ST_IDLE;
            done       <= ev_finish;
            id_valid   <= (ev_err == ERR_NONE);
            id_error   <= (ev_err != ERR_NONE);
            err_code   <= ev_err;
            page_count <= ev_geom.pages;
            page_size  <= ev_geom.psize;
            addr_shift <= ev_geom.shift;
            pow2_pages <= ev_geom.pow2;
            capacity   <= CAP_W'(ev_geom.pages) * CAP_W'(ev_geom.psize);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle"); // R8
  AST_DONE_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    done |-> (id_valid ^ id_error)) else $error("done without exactly one flag"); // R8
  AST_GEOM_HELD: assert property (@(posedge clk) disable iff (rst)
    !$stable(capacity) |-> done) else $error("capacity moved without done"); // R8
  AST_RUN_ENDS_DONE: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done)) else $error("run left without done"); // R8
  AST_CS_HIGH_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> spi_cs_n) else $error("chip select low while idle"); // R9
  AST_SHIFT_IDLE_AT_EVAL: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EVAL) |-> !sh_busy) else $error("evaluation during shift"); // R9
  AST_ERROR_CODED: assert property (@(posedge clk) disable iff (rst)
    id_error |-> (err_code != 2'd0)) else $error("error without code"); // R5
  AST_VALID_UNCODED: assert property (@(posedge clk) disable iff (rst)
    id_valid |-> (err_code == 2'd0)) else $error("valid with error code"); // R6
  AST_POW2_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    (id_valid && pow2_pages) |-> ($countones(page_size) == 1)) else $error("pow2 size shape"); // R3
  AST_EXT_TWO_BITS: assert property (@(posedge clk) disable iff (rst)
    (id_valid && !pow2_pages) |-> ($countones(page_size) == 2)) else $error("extended size shape"); // R4
  AST_CAP_PRODUCT: assert property (@(posedge clk) disable iff (rst)
    id_valid |-> (capacity == CAP_W'(page_count) * CAP_W'(page_size))) else $error("capacity mismatch"); // R7

endmodule

// File: tb/flash_id_engine_bench.sv
`timescale 1ns/1ps
module flash_id_engine_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        spi_miso = 1'b1;
  logic        spi_sclk, spi_cs_n, spi_mosi;
  logic        busy, done, id_valid, id_error;
  logic [1:0]  err_code;
  logic [15:0] page_count;
  logic [10:0] page_size;
  logic [3:0]  addr_shift;
  logic        pow2_pages;
  logic [26:0] capacity;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  flash_id_engine #(.SCLK_HALF_CYCLES(2)) u_flash_id_engine (
    .clk(clk), .rst(rst), .start(start), .spi_miso(spi_miso),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .busy(busy), .done(done), .id_valid(id_valid), .id_error(id_error),
    .err_code(err_code), .page_count(page_count), .page_size(page_size),
    .addr_shift(addr_shift), .pow2_pages(pow2_pages), .capacity(capacity)
  );

  // ---------------- flash model ----------------
  bit          m_jedec_en = 1'b1;
  logic [23:0] m_id = 24'h1F2600;
  logic [7:0]  m_status = 8'h81;
  logic [7:0]  m_op = 8'h00;
  int          m_bit = 0;
  int          ntrans = 0;
  logic [7:0]  rec_op [128];
  int          rec_bits [128];

  function automatic logic [7:0] resp_byte(input int n);
    if (m_op == 8'h9F) begin
      if (!m_jedec_en) return 8'hFF;
      case (n)
        0: return m_id[23:16];
        1: return m_id[15:8];
        2: return m_id[7:0];
        default: return 8'h00;
      endcase
    end else if (m_op == 8'hD7) begin
      return m_status;
    end
    return 8'hFF;
  endfunction

  always @(posedge spi_sclk or posedge spi_cs_n) begin
    if (spi_cs_n) begin
      if (m_bit > 0) begin
        rec_op[ntrans % 128]   = m_op;
        rec_bits[ntrans % 128] = m_bit;
        ntrans = ntrans + 1;
      end
      m_bit = 0;
      m_op  = 8'h00;
    end else begin
      if (m_bit < 8) m_op = {m_op[6:0], spi_mosi};
      m_bit = m_bit + 1;
    end
  end

  always @(negedge spi_sclk) begin
    logic [7:0] b;
    if (!spi_cs_n && m_bit >= 8) begin
      b = resp_byte((m_bit - 8) / 8);
      spi_miso = b[7 - ((m_bit - 8) % 8)];
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic configure(input bit jen, input logic [23:0] id, input logic [7:0] st);
    m_jedec_en = jen;
    m_id       = id;
    m_status   = st;
  endtask

  task automatic expect_geom(input string req, input int base, input int pages, input int psize,
                             input int shift, input bit p2, input int ntr, input logic [7:0] op2);
    bit ok;
    wait_done(ok);
    chk(req, "done seen", ok, 1);
    chk(req, "valid", id_valid, 1);
    chk(req, "error", id_error, 0);
    chk(req, "err_code", err_code, 0);
    chk(req, "page_count", page_count, pages);
    chk(req, "page_size", page_size, psize);
    chk(req, "addr_shift", addr_shift, shift);
    chk(req, "pow2", pow2_pages, p2);
    chk("R7", "capacity", capacity, longint'(pages) * psize);
    chk(req, "transactions", ntrans - base, ntr);
    chk("R1", "first opcode", rec_op[base % 128], 8'h9F);
    chk("R9", "id transaction edges", rec_bits[base % 128], 32);
    if (ntr > 1) begin
      chk(req, "second opcode", rec_op[(base + 1) % 128], op2);
      chk("R9", "status transaction edges", rec_bits[(base + 1) % 128], 16);
    end
    @(negedge clk);
    chk("R8", "done one cycle", done, 0);
  endtask

  task automatic expect_err(input string req, input int base, input int code, input int ntr);
    bit ok;
    wait_done(ok);
    chk(req, "done seen", ok, 1);
    chk(req, "valid", id_valid, 0);
    chk(req, "error", id_error, 1);
    chk(req, "err_code", err_code, code);
    chk("R7", "capacity after error", capacity, 0);
    chk(req, "transactions", ntrans - base, ntr);
  endtask

  task automatic run_geom(input string req, input bit jen, input logic [23:0] id, input logic [7:0] st,
                          input int pages, input int psize, input int shift, input bit p2, input int ntr);
    int base;
    configure(jen, id, st);
    base = ntrans;
    pulse_start();
    expect_geom(req, base, pages, psize, shift, p2, ntr, 8'hD7);
  endtask

  task automatic run_err(input string req, input bit jen, input logic [23:0] id, input logic [7:0] st,
                         input int code, input int ntr);
    int base;
    configure(jen, id, st);
    base = ntrans;
    pulse_start();
    expect_err(req, base, code, ntr);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_and_boot();
    configure(1'b1, 24'h1F2600, 8'h81);
    repeat (5) @(negedge clk);
    chk("R9", "cs_n in reset", spi_cs_n, 1);
    chk("R9", "sclk in reset", spi_sclk, 0);
    chk("R8", "done in reset", done, 0);
    chk("R8", "valid in reset", id_valid, 0);
    chk("R8", "error in reset", id_error, 0);
    rst = 1'b0;
    expect_geom("R1", 0, 4096, 512, 9, 1'b1, 2, 8'hD7);
  endtask

  task automatic t_jedec_qualified();
    run_geom("R3", 1'b1, 24'h1F2600, 8'h2C, 4096, 528, 10, 1'b0, 2);
    run_geom("R3", 1'b1, 24'h1F2200, 8'h01, 512, 256, 8, 1'b1, 2);
    run_geom("R3", 1'b1, 24'h1F2300, 8'hFE, 1024, 264, 9, 1'b0, 2);
    run_geom("R3", 1'b1, 24'h1F2800, 8'h00, 8192, 1056, 11, 1'b0, 2);
    run_geom("R3", 1'b1, 24'h1F2800, 8'hFF, 8192, 1024, 10, 1'b1, 2);
    run_geom("R3", 1'b1, 24'h1F2701, 8'h01, 8192, 512, 9, 1'b1, 2);
    run_geom("R3", 1'b1, 24'h1F2500, 8'h80, 4096, 264, 9, 1'b0, 2);
  endtask

  task automatic t_jedec_fixed();
    run_geom("R2", 1'b1, 24'h1F2700, 8'h01, 8192, 528, 10, 1'b0, 1);
  endtask

  task automatic t_jedec_unknown();
    run_err("R6", 1'b1, 24'h1F2900, 8'h81, 2, 1);
    run_err("R6", 1'b1, 24'h1F2601, 8'h81, 2, 1);
  endtask

  task automatic t_density_table();
    run_geom("R4", 1'b0, 24'h0, 8'h8C, 512, 264, 9, 1'b0, 2);
    run_geom("R4", 1'b0, 24'h0, 8'h97, 1024, 264, 9, 1'b0, 2);
    run_geom("R4", 1'b0, 24'h0, 8'h1C, 2048, 264, 9, 1'b0, 2);
    run_geom("R4", 1'b0, 24'h0, 8'hA4, 4096, 264, 9, 1'b0, 2);
    run_geom("R4", 1'b0, 24'h0, 8'hAD, 4096, 528, 10, 1'b0, 2);
    run_geom("R4", 1'b0, 24'h0, 8'hB4, 8192, 528, 10, 1'b0, 2);
    run_geom("R4", 1'b0, 24'h0, 8'hB8, 8192, 1056, 11, 1'b0, 2);
    run_geom("R4", 1'b0, 24'h0, 8'hBF, 8192, 1056, 11, 1'b0, 2);
    run_geom("R4", 1'b1, 24'hC22015, 8'h9C, 2048, 264, 9, 1'b0, 2);
  endtask

  task automatic t_no_device();
    run_err("R5", 1'b0, 24'h0, 8'hFF, 1, 2);
    run_err("R5", 1'b0, 24'h0, 8'h00, 1, 2);
  endtask

  task automatic t_unlisted_density();
    run_err("R6", 1'b0, 24'h0, 8'h90, 2, 2);
    run_err("R6", 1'b0, 24'h0, 8'h84, 2, 2);
  endtask

  task automatic t_start_while_busy();
    int base;
    int extra;
    bit ok;
    configure(1'b1, 24'h1F2700, 8'h00);
    base = ntrans;
    pulse_start();
    repeat (30) @(negedge clk);
    chk("R8", "busy mid run", busy, 1);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done(ok);
    chk("R8", "done after restart attempt", ok, 1);
    chk("R8", "page_count", page_count, 8192);
    extra = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R8", "no second run", extra, 0);
    chk("R8", "transactions", ntrans - base, 1);
  endtask

  task automatic t_hold_outputs();
    logic [26:0] cap0;
    logic [10:0] ps0;
    logic [3:0]  sh0;
    int seen;
    cap0 = capacity; ps0 = page_size; sh0 = addr_shift;
    configure(1'b0, 24'h0, 8'hFF);
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (done || busy || spi_sclk || !spi_cs_n) seen++;
    end
    chk("R8", "quiet while idle", seen, 0);
    chk("R8", "capacity held", capacity, cap0);
    chk("R8", "page_size held", page_size, ps0);
    chk("R8", "addr_shift held", addr_shift, sh0);
    chk("R8", "valid held", id_valid, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_and_boot();
    t_jedec_qualified();
    t_jedec_fixed();
    t_hold_outputs();
    t_jedec_unknown();
    t_density_table();
    t_no_device();
    t_unlisted_density();
    t_start_while_busy();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule